// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block gathers five interrupt request flags (two external lines, two timer overflow flags and one serial port flag) and turns them into one vector request toward a processor core. Software programs two small registers through a byte-wide port. One register holds a per-source enable mask and a master enable. The other assigns each source to either the high or the low priority level.

Request flags are captured in a sampling register at each clock edge, and the arbitration in the following cycle works only on that captured copy. Among the sampled, enabled sources, a high-level source beats a low-level one. Within one level, the lowest source index wins. When the core takes a request on `cpu_ack`, the arbiter marks that level as in service. A high-level request can still interrupt a low-level handler. Any other new request waits until the handler ends with a pulse on `irq_ret`, which clears the highest in-service mark.

Top module: `intr_prio_arb`

## Requirements
- R1: After reset, both registers read back as 0x00, no level is in service, and `cpu_req` is 0.
- R2: Source index i is carried on `src_req[i]`, enabled by bit i of the enable register and reported as `cpu_vec = i`. The indices are: 0 external line A, 1 timer A, 2 external line B, 3 timer B, 4 serial port.
- R3: `reg_sel = 0` selects the enable register. Its bits 6 and 5 ignore writes and always read as 0, so writing 0xFF reads back as 0x9F.
- R4: Bit 7 of the enable register is a master enable. While it is 0, `cpu_req` stays 0 whatever the per-source bits hold.
- R5: `reg_sel = 1` selects the priority register. Bit i set puts source i on the high level (`cpu_lvl = 1`), and bits 7..5 read as 0.
- R6: A flag present on `src_req` at a clock edge is sampled there. It can raise `cpu_req` only after that edge, and `cpu_req` tracks the sampled copy, not the live input.
- R7: When several enabled sampled sources compete, any high-level source wins over all low-level ones. Within the winning level, the lowest index is reported.
- R8: `cpu_ack` while `cpu_req` is 1 marks the granted level as in service. While the high level is in service no request is issued. While only the low level is in service, only high-level requests are issued.
- R9: An `irq_ret` pulse clears the high in-service mark if it is set, and otherwise clears the low one. A grant in the same cycle sets its mark after that clearing.
- R10: `cpu_ack` while `cpu_req` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 enable, 1 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 5 | Raw request flags, one per source index |
| cpu_req | output | 1 | Vector request to the core |
| cpu_vec | output | 3 | Index of the requesting source |
| cpu_lvl | output | 1 | Level of the request: 1 high, 0 low |
| cpu_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Return-from-handler strobe |

## Verification
The hardest state to reach is nesting: both in-service marks set, new requests waiting on both levels, and a return pulse that must release only the high mark, sometimes in the same cycle as another grant. Random cycles acknowledge and return often, so this nesting happens repeatedly under mixed enable and priority settings. A directed sequence also grants low, preempts with high, and then returns twice with requests held on both levels.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int NSRC   = 5;
  localparam int VW     = 3;
  localparam int DW     = 8;
  localparam int GBIT   = 7;
  localparam logic [DW-1:0] EN_KEEP = 8'h9F;

  // lowest set index of a request vector (0 if empty)
  function automatic logic [VW-1:0] lowest_idx(input logic [NSRC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  // mask of indices strictly below idx
  function automatic logic [NSRC-1:0] below_mask(input logic [VW-1:0] idx);
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (VW'(i) < idx) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/intr_arb_regs.sv
module intr_arb_regs
  import intr_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] en_src,
  output logic            en_all,
  output logic [NSRC-1:0] prio
);
  logic [DW-1:0]   wkeep;
  logic [NSRC-1:0] en_q, pr_q;
  logic            all_q;

  assign wkeep = wdata & EN_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      all_q <= 1'b0;
      pr_q  <= '0;
    end else if (we) begin
      if (sel) begin
        pr_q <= wdata[NSRC-1:0];
      end else begin
        en_q  <= wkeep[NSRC-1:0];
        all_q <= wkeep[GBIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[NSRC-1:0] = pr_q;
    end else begin
      rdata[NSRC-1:0] = en_q;
      rdata[GBIT]     = all_q;
    end
  end

  assign en_src = en_q;
  assign en_all = all_q;
  assign prio   = pr_q;

  assert_glob_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel) |=> (en_all == $past(wdata[GBIT])));
  assert_prio_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> (prio == $past(wdata[NSRC-1:0])));
endmodule

// File: rtl/intr_arb_sample.sv
module intr_arb_sample
  import intr_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] smp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= raw;
  end
endmodule

// File: rtl/intr_arb_select.sv
module intr_arb_select
  import intr_arb_pkg::*;
(
  input  logic [NSRC-1:0] smp,
  input  logic [NSRC-1:0] en_src,
  input  logic            en_all,
  input  logic [NSRC-1:0] prio,
  input  logic            ins_hi,
  input  logic            ins_lo,
  output logic            req,
  output logic [VW-1:0]   vec,
  output logic            lvl
);
  logic [NSRC-1:0] elig, hi_set, lo_set;

  assign elig   = smp & en_src & {NSRC{en_all}};
  assign hi_set = elig & prio;
  assign lo_set = elig & ~prio;

  always_comb begin
    req = 1'b0;
    lvl = 1'b0;
    vec = '0;
    if (!ins_hi && (hi_set != '0)) begin
      req = 1'b1;
      lvl = 1'b1;
      vec = lowest_idx(hi_set);
    end else if (!ins_hi && !ins_lo && (lo_set != '0)) begin
      req = 1'b1;
      vec = lowest_idx(lo_set);
    end
  end
endmodule

// File: rtl/intr_arb_inservice.sv
module intr_arb_inservice (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic grant_lvl,
  input  logic ret,
  output logic ins_hi,
  output logic ins_lo
);
  logic clr_hi, clr_lo, set_hi, set_lo;

  assign clr_hi = ret && ins_hi;
  assign clr_lo = ret && !ins_hi;
  assign set_hi = grant && grant_lvl;
  assign set_lo = grant && !grant_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= (ins_hi && !clr_hi) || set_hi;
      ins_lo <= (ins_lo && !clr_lo) || set_lo;
    end
  end

  assert_ret_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ins_hi && !grant) |=> !ins_hi);
  assert_ret_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ins_lo && !ins_hi && !grant) |=> !ins_lo);
  assert_ret_keep_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ins_hi && ins_lo) |=> ins_lo);
endmodule

// File: rtl/intr_prio_arb.sv
module intr_prio_arb
  import intr_arb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [4:0]    src_req,
  output logic          cpu_req,
  output logic [2:0]    cpu_vec,
  output logic          cpu_lvl,
  input  logic          cpu_ack,
  input  logic          irq_ret
);
  logic [NSRC-1:0] en_src, prio, smp;
  logic            en_all, ins_hi, ins_lo;
  logic            grant;

  intr_arb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_src(en_src), .en_all(en_all), .prio(prio)
  );

  intr_arb_sample u_smp (
    .clk(clk), .rst_n(rst_n), .raw(src_req), .smp(smp)
  );

  intr_arb_select u_sel (
    .smp(smp), .en_src(en_src), .en_all(en_all), .prio(prio),
    .ins_hi(ins_hi), .ins_lo(ins_lo),
    .req(cpu_req), .vec(cpu_vec), .lvl(cpu_lvl)
  );

  assign grant = cpu_req && cpu_ack;

  intr_arb_inservice u_ins (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_lvl(cpu_lvl),
    .ret(irq_ret), .ins_hi(ins_hi), .ins_lo(ins_lo)
  );

  // named events for the checks below
  logic [NSRC-1:0] lvl_pool;
  logic            vec_in_pool, lower_free;
  assign lvl_pool    = smp & en_src & (cpu_lvl ? prio : ~prio);
  assign vec_in_pool = ((lvl_pool >> cpu_vec) & NSRC'(1)) != '0;
  assign lower_free  = (lvl_pool & below_mask(cpu_vec)) == '0;

  assert_master_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> en_all);
  assert_sampled_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> ((($past(src_req) >> cpu_vec) & 5'd1) != 5'd0));
  assert_pick_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (vec_in_pool && lower_free));
  assert_high_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_lvl) |-> ((smp & en_src & prio) == '0));
  assert_hi_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !cpu_req);
  assert_lo_only_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && cpu_req) |-> cpu_lvl);
  assert_ack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_req && !irq_ret) |=> ($stable(ins_hi) && $stable(ins_lo)));
endmodule

// File: tb/intr_prio_arb_test.sv
module intr_prio_arb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_sel = 1'b0, cpu_ack = 1'b0, irq_ret = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [4:0] src_req = '0;
  logic [7:0] reg_rdata;
  logic       cpu_req, cpu_lvl;
  logic [2:0] cpu_vec;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] m_en;
  logic [4:0] m_pr, m_smp;
  logic       m_hi, m_lo;

  intr_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_lvl(cpu_lvl),
    .cpu_ack(cpu_ack), .irq_ret(irq_ret)
  );

  always #10 clk = ~clk;

  // expected request as {req, lvl, vec}
  function automatic logic [4:0] expect_req();
    logic [4:0] pool;
    logic       hl;
    int         k;
    if (!m_en[7] || m_hi) return 5'd0;
    pool = m_smp & m_en[4:0] & m_pr;
    hl   = 1'b1;
    if (pool == 0) begin
      if (m_lo) return 5'd0;
      pool = m_smp & m_en[4:0] & ~m_pr;
      hl   = 1'b0;
    end
    if (pool == 0) return 5'd0;
    k = 0;
    while (!pool[k]) k++;
    return {1'b1, hl, k[2:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] s, input logic ack, input logic ret,
                      input logic we, input logic sel, input logic [7:0] wd,
                      input string tag);
    logic [4:0] e;
    src_req = s; cpu_ack = ack; irq_ret = ret;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    e = expect_req();
    @(posedge clk);
    if (we) begin
      if (sel) m_pr = wd[4:0];
      else     m_en = wd & 8'h9F;
    end
    m_smp = s;
    if (ret) begin
      if (m_hi) m_hi = 1'b0;
      else      m_lo = 1'b0;
    end
    if (ack && e[4]) begin
      if (e[3]) m_hi = 1'b1;
      else      m_lo = 1'b1;
    end
    @(negedge clk);
    e = expect_req();
    check({tag, " req"}, {7'd0, cpu_req}, {7'd0, e[4]});
    if (e[4]) begin
      check({tag, " vec"}, {5'd0, cpu_vec}, {5'd0, e[2:0]});
      check({tag, " lvl"}, {7'd0, cpu_lvl}, {7'd0, e[3]});
    end
    check({tag, " rdata"}, reg_rdata, reg_sel ? {3'd0, m_pr} : m_en);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_en = '0; m_pr = '0; m_smp = '0; m_hi = 0; m_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 1'b0; #1;
    check("R1 en", reg_rdata, 8'h00);
    reg_sel = 1'b1; #1;
    check("R1 prio", reg_rdata, 8'h00);
    check("R1 req", {7'd0, cpu_req}, 8'h00);
    @(negedge clk);
    // R3 reserved bits
    step(5'h00, 0, 0, 1, 0, 8'hFF, "R3");
    check("R3 readback", reg_rdata, 8'h9F);
    // R5 priority register width
    step(5'h00, 0, 0, 1, 1, 8'hFF, "R5");
    check("R5 readback", reg_rdata, 8'h1F);
    // R4 master enable off
    step(5'h00, 0, 0, 1, 0, 8'h1F, "R4");
    step(5'h1F, 0, 0, 0, 0, 8'h00, "R4");
    step(5'h1F, 0, 0, 0, 0, 8'h00, "R4");
    check("R4 gated", {7'd0, cpu_req}, 8'h00);
    // R6 timing: single pulse on timer B (index 3, R2)
    step(5'h00, 0, 0, 1, 0, 8'h9F, "R6");
    step(5'h00, 0, 0, 1, 1, 8'h00, "R6");
    step(5'h08, 0, 0, 0, 0, 8'h00, "R6");
    check("R2 vec timer B", {5'd0, cpu_vec}, 8'd3);
    step(5'h00, 0, 0, 0, 0, 8'h00, "R6");
    check("R6 drop", {7'd0, cpu_req}, 8'h00);
    // R7 ordering: serial high against all low
    step(5'h00, 0, 0, 1, 1, 8'h10, "R7");
    step(5'h1F, 0, 0, 0, 0, 8'h00, "R7");
    check("R7 high wins", {4'd0, cpu_lvl, cpu_vec}, 8'h0C);
    step(5'h1F, 0, 0, 1, 1, 8'h00, "R7");
    check("R7 lowest", {4'd0, cpu_lvl, cpu_vec}, 8'h00);
    // R10 ack with no request
    step(5'h00, 0, 0, 0, 0, 8'h00, "R10");
    step(5'h00, 1, 0, 0, 0, 8'h00, "R10");
    step(5'h01, 0, 0, 0, 0, 8'h00, "R10");
    check("R10 still free", {7'd0, cpu_req}, 8'h01);
    // R8/R9 nesting: grant low, preempt with high, return twice
    step(5'h01, 1, 0, 1, 1, 8'h02, "R8");
    step(5'h03, 0, 0, 0, 0, 8'h00, "R8");
    check("R8 preempt", {4'd0, cpu_lvl, cpu_vec}, 8'h09);
    step(5'h03, 1, 0, 0, 0, 8'h00, "R8");
    check("R8 both busy", {7'd0, cpu_req}, 8'h00);
    step(5'h03, 0, 1, 0, 0, 8'h00, "R9");
    check("R9 high released", {4'd0, cpu_req, cpu_lvl}, 8'h03);
    step(5'h01, 0, 0, 0, 0, 8'h00, "R9");
    check("R9 low still held", {7'd0, cpu_req}, 8'h00);
    step(5'h01, 0, 1, 0, 0, 8'h00, "R9");
    check("R9 low released", {7'd0, cpu_req}, 8'h01);
    // random phase, fixed seed
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4000; i++) begin
      step(5'($urandom), ($urandom % 3) == 0, ($urandom % 6) == 0,
           ($urandom % 10) == 0, 1'($urandom), 8'($urandom) | 8'h80,
           "R7 R8 R9");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule